// File: doc/BRIEF.md
# Page Memory Access Address Sequencer

This block sits between a host port and a text page store organised as 128 pages of 1 KB each. It keeps the current access position: a 7-bit page number, a row from 0 to 25 and a column from 0 to 39. The host can load each of the three fields directly. It can also issue byte writes and byte reads at the current position. The block converts row and column into a 10-bit linear offset inside the page and moves the byte over a 4-bit memory port as two nibble cycles. Each nibble cycle uses a request/acknowledge handshake.

After every completed byte access, the column steps forward by one. A wrap from column 39 carries into the row, and row 23 wraps to row 0. Rows 24 and 25 are special rows. Auto-advance never enters them, and a column wrap inside them leaves the row unchanged, so the host reaches them only by a direct load. While a nibble pair is in flight, the block reports busy and ignores every host command.

Top module: `pgseq_top`

## Requirements
- R1: After reset, page, row and column are 0, busy is low and no memory request is raised.
- R2: A load of page, row or column takes its value from the load data bus: page from bits 6:0, row and column from the whole byte. The load is accepted only when the block is idle and no access is requested in the same cycle.
- R3: A row load with a value above 25 or a column load with a value above 39 is ignored and leaves the field unchanged; row never exceeds 25 and column never exceeds 39.
- R4: A write moves the byte as two memory cycles with write enable high, low nibble (bits 3:0) first with nibble select 0, then the high nibble with nibble select 1; the next nibble starts only after the acknowledge of the previous one.
- R5: When a byte access completes, the column advances by one, unless a wrap rule of R6 to R8 applies.
- R6: In rows 0 to 22, an access at column 39 sets the column to 0 and advances the row by one.
- R7: An access at row 23, column 39 moves the position to row 0, column 0.
- R8: An access at column 39 in row 24 or 25 sets the column to 0 and leaves the row unchanged.
- R9: A read takes the low nibble from the first cycle and the high nibble from the second. It presents the byte on rdata_o with a one-cycle rdata_vld_o pulse after the second acknowledge. The position holds while the read is in progress and advances only when the read completes.
- R10: While busy is high, loads, writes and reads are ignored; a write has priority over a simultaneous read.
- R11: The memory address is {page, offset, nibble select}. The page takes bits 17:11, the offset bits 10:1 and the nibble select bit 0. The offset is (row*40 + column) modulo 1024.
- R12: The memory address stays stable while a request is waiting for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_page_i | input | 1 | Load page number from ld_data_i |
| ld_row_i | input | 1 | Load row from ld_data_i |
| ld_col_i | input | 1 | Load column from ld_data_i |
| ld_data_i | input | 8 | Load value |
| wr_i | input | 1 | Start byte write at the current position |
| wdata_i | input | 8 | Byte to write |
| rd_i | input | 1 | Start byte read at the current position |
| rdata_o | output | 8 | Last byte read |
| rdata_vld_o | output | 1 | One-cycle pulse when rdata_o is updated |
| busy_o | output | 1 | Nibble pair in progress |
| page_o | output | 7 | Current page |
| row_o | output | 5 | Current row |
| col_o | output | 6 | Current column |
| mem_req_o | output | 1 | Nibble cycle request |
| mem_we_o | output | 1 | Nibble cycle is a write |
| mem_addr_o | output | 18 | {page, offset, nibble select} |
| mem_wdata_o | output | 4 | Nibble to write |
| mem_rdata_i | input | 4 | Nibble read |
| mem_ack_i | input | 1 | Nibble cycle done |

## Verification
The hardest case to reach is a host command that arrives while a nibble pair is still waiting on the memory. The command must leave no trace. To create this, the bench memory responder delays its acknowledge by several cycles. A load, a write and a read are all pulsed in the middle of the delay. The bench then checks that only two nibble writes reached the port and that the column moved by exactly one. The row-24/25 and modulo-1024 cases are reached by direct loads to column 39 and to row 25, column 30.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  localparam int PAGE_W   = 7;
  localparam int ROW_W    = 5;
  localparam int COL_W    = 6;
  localparam int OFS_W    = 10;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int N_COLS   = 40;
  localparam int N_ROWS   = 26;
  localparam int WRAP_ROW = 24;  // first row excluded from auto-advance

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_RUN  = 1'b1
  } acc_state_e;
endpackage

// File: rtl/pgseq_pos.sv
module pgseq_pos #(
  parameter int PAGE_W   = pgseq_pkg::PAGE_W,
  parameter int ROW_W    = pgseq_pkg::ROW_W,
  parameter int COL_W    = pgseq_pkg::COL_W,
  parameter int LD_W     = pgseq_pkg::DATA_W,
  parameter int N_COLS   = pgseq_pkg::N_COLS,
  parameter int N_ROWS   = pgseq_pkg::N_ROWS,
  parameter int WRAP_ROW = pgseq_pkg::WRAP_ROW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic              ld_page_i,
  input  logic              ld_row_i,
  input  logic              ld_col_i,
  input  logic [LD_W-1:0]   ld_data_i,
  input  logic              adv_i,
  input  logic              busy_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  localparam logic [COL_W-1:0] COL_LAST  = COL_W'(N_COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(N_ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_WLAST = ROW_W'(WRAP_ROW - 1);

  logic [PAGE_W-1:0] page_q;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              row_ok, col_ok;

  assign row_ok = ld_data_i <= LD_W'(N_ROWS - 1);
  assign col_ok = ld_data_i <= LD_W'(N_COLS - 1);

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (adv_i) begin
      if (col_q == COL_LAST) begin
        col_d = '0;
        if (row_q == ROW_WLAST)    row_d = '0;
        else if (row_q < ROW_WLAST) row_d = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end else if (ld_en_i) begin
      if (ld_row_i && row_ok) row_d = ROW_W'(ld_data_i);
      if (ld_col_i && col_ok) col_d = COL_W'(ld_data_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      if (!adv_i && ld_en_i && ld_page_i) page_q <= ld_data_i[PAGE_W-1:0];
    end
  end

  assign page_o = page_q;
  assign row_o  = row_q;
  assign col_o  = col_q;

  AST_ROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= ROW_LAST);  // R3
  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_LAST);  // R3
  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !adv_i) |=> ($stable(row_q) && $stable(col_q) && $stable(page_q)));  // R10
  AST_WRAP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && row_q == ROW_WLAST && col_q == COL_LAST) |=> (row_q == '0 && col_q == '0));  // R7
  AST_SPECIAL_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && row_q > ROW_WLAST) |=> $stable(row_q));  // R8
endmodule

// File: rtl/pgseq_ofs.sv
module pgseq_ofs #(
  parameter int ROW_W  = pgseq_pkg::ROW_W,
  parameter int COL_W  = pgseq_pkg::COL_W,
  parameter int OFS_W  = pgseq_pkg::OFS_W,
  parameter int N_COLS = pgseq_pkg::N_COLS
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [OFS_W-1:0] ofs_o
);
  localparam int PROD_W = ROW_W + COL_W + 1;

  logic [PROD_W-1:0] lin;

  // offset wraps modulo the page size by truncation
  assign lin   = PROD_W'(row_i) * PROD_W'(N_COLS) + PROD_W'(col_i);
  assign ofs_o = lin[OFS_W-1:0];
endmodule

// File: rtl/pgseq_nib.sv
module pgseq_nib #(
  parameter int DATA_W = pgseq_pkg::DATA_W,
  parameter int NIB_W  = pgseq_pkg::NIB_W,
  localparam int NIBS   = DATA_W / NIB_W,
  localparam int NIB_CW = (NIBS > 1) ? $clog2(NIBS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              busy_o,
  output logic              adv_o,
  output logic [NIB_CW-1:0] nib_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [NIB_W-1:0]  mem_wdata_o,
  input  logic [NIB_W-1:0]  mem_rdata_i,
  input  logic              mem_ack_i
);
  import pgseq_pkg::*;

  localparam logic [NIB_CW-1:0] NIB_LAST = NIB_CW'(NIBS - 1);

  acc_state_e        state_q;
  logic [NIB_CW-1:0] nib_q;
  logic              we_q;
  logic [DATA_W-1:0] byte_q, rbuf_q, rbuf_d, rdata_q;
  logic              vld_q;
  logic              fire, last;

  assign fire = (state_q == ACC_RUN) && mem_ack_i;
  assign last = nib_q == NIB_LAST;

  always_comb begin
    rbuf_d = rbuf_q;
    rbuf_d[nib_q*NIB_W +: NIB_W] = mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACC_IDLE;
      nib_q   <= '0;
      we_q    <= 1'b0;
      byte_q  <= '0;
      rbuf_q  <= '0;
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (state_q == ACC_IDLE) begin
        if (wr_i || rd_i) begin
          state_q <= ACC_RUN;
          nib_q   <= '0;
          we_q    <= wr_i;
          byte_q  <= wdata_i;
        end
      end else if (fire) begin
        if (!we_q) rbuf_q <= rbuf_d;
        if (last) begin
          state_q <= ACC_IDLE;
          if (!we_q) begin
            rdata_q <= rbuf_d;
            vld_q   <= 1'b1;
          end
        end else begin
          nib_q <= nib_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = state_q == ACC_RUN;
  assign adv_o       = fire && last;
  assign nib_o       = nib_q;
  assign mem_req_o   = state_q == ACC_RUN;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = byte_q[nib_q*NIB_W +: NIB_W];
  assign rdata_o     = rdata_q;
  assign rdata_vld_o = vld_q;

  AST_NIB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !last) |=> (mem_req_o && nib_q != '0));  // R4
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> nib_q == '0);  // R4
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |=> !rdata_vld_o);  // R9
  AST_VLD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |-> ($past(mem_ack_i) && !$past(mem_we_o) && !busy_o));  // R9
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top #(
  parameter int PAGE_W   = pgseq_pkg::PAGE_W,
  parameter int ROW_W    = pgseq_pkg::ROW_W,
  parameter int COL_W    = pgseq_pkg::COL_W,
  parameter int OFS_W    = pgseq_pkg::OFS_W,
  parameter int DATA_W   = pgseq_pkg::DATA_W,
  parameter int NIB_W    = pgseq_pkg::NIB_W,
  parameter int N_COLS   = pgseq_pkg::N_COLS,
  parameter int N_ROWS   = pgseq_pkg::N_ROWS,
  parameter int WRAP_ROW = pgseq_pkg::WRAP_ROW,
  localparam int NIBS    = DATA_W / NIB_W,
  localparam int NIB_CW  = (NIBS > 1) ? $clog2(NIBS) : 1,
  localparam int MADDR_W = PAGE_W + OFS_W + NIB_CW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ld_page_i,
  input  logic               ld_row_i,
  input  logic               ld_col_i,
  input  logic [DATA_W-1:0]  ld_data_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rdata_vld_o,
  output logic               busy_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [COL_W-1:0]   col_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [NIB_W-1:0]   mem_wdata_o,
  input  logic [NIB_W-1:0]   mem_rdata_i,
  input  logic               mem_ack_i
);
  logic              busy, adv, ld_en;
  logic [NIB_CW-1:0] nib;
  logic [OFS_W-1:0]  ofs;

  assign ld_en = !busy && !wr_i && !rd_i;

  pgseq_pos #(
    .PAGE_W(PAGE_W), .ROW_W(ROW_W), .COL_W(COL_W), .LD_W(DATA_W),
    .N_COLS(N_COLS), .N_ROWS(N_ROWS), .WRAP_ROW(WRAP_ROW)
  ) u_pos (
    .clk_i, .rst_ni,
    .ld_en_i(ld_en), .ld_page_i, .ld_row_i, .ld_col_i, .ld_data_i,
    .adv_i(adv), .busy_i(busy),
    .page_o, .row_o, .col_o
  );

  pgseq_ofs #(
    .ROW_W(ROW_W), .COL_W(COL_W), .OFS_W(OFS_W), .N_COLS(N_COLS)
  ) u_ofs (
    .row_i(row_o), .col_i(col_o), .ofs_o(ofs)
  );

  pgseq_nib #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_nib (
    .clk_i, .rst_ni,
    .wr_i, .rd_i, .wdata_i,
    .rdata_o, .rdata_vld_o,
    .busy_o(busy), .adv_o(adv), .nib_o(nib),
    .mem_req_o, .mem_we_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i
  );

  assign busy_o     = busy;
  assign mem_addr_o = {page_o, ofs, nib};

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o));  // R12
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !wr_i && !rd_i) |=> !mem_req_o);  // R1
endmodule

// File: tb/pgseq_top_tb_top.sv
module pgseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_page = 1'b0, ld_row = 1'b0, ld_col = 1'b0;
  logic [7:0]  ld_data = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_vld, busy;
  logic [6:0]  page;
  logic [4:0]  row;
  logic [5:0]  col;
  logic        mem_req, mem_we;
  logic [17:0] mem_addr;
  logic [3:0]  mem_wdata, mem_rdata;
  logic        mem_ack = 1'b0;

  int checks = 0, fails = 0;
  int lat = 0;
  int wcnt = 0;
  int nlog = 0;
  logic [17:0] log_addr [8];
  logic [3:0]  log_dat  [8];
  bit done = 0;

  always #4 clk = ~clk;

  pgseq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_page_i(ld_page), .ld_row_i(ld_row), .ld_col_i(ld_col), .ld_data_i(ld_data),
    .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .rdata_vld_o(rdata_vld), .busy_o(busy),
    .page_o(page), .row_o(row), .col_o(col),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  function automatic logic [3:0] nib_model(logic [17:0] a);
    return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12] ^ {2'b00, a[17:16]} ^ 4'h5;
  endfunction

  function automatic logic [9:0] exp_ofs(int r, int c);
    return 10'((r * 40 + c) % 1024);
  endfunction

  assign mem_rdata = nib_model(mem_addr);

  // memory responder with programmable acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wcnt >= lat) begin
          mem_ack = 1'b1;
          wcnt = 0;
          if (mem_we && nlog < 8) begin
            log_addr[nlog] = mem_addr;
            log_dat[nlog]  = mem_wdata;
            nlog++;
          end
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(int kind, int v);
    @(negedge clk);
    ld_data = 8'(v);
    ld_page = (kind == 0);
    ld_row  = (kind == 1);
    ld_col  = (kind == 2);
    @(negedge clk);
    ld_page = 1'b0; ld_row = 1'b0; ld_col = 1'b0;
  endtask

  task automatic set_pos(int p, int r, int c);
    load(0, p); load(1, r); load(2, c);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_write(logic [7:0] b);
    @(negedge clk);
    wr = 1'b1; wdata = b;
    @(negedge clk);
    wr = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 page", int'(page), 0);
    chk("R1 row", int'(row), 0);
    chk("R1 col", int'(col), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 req", int'(mem_req), 0);
  endtask

  task automatic t_load();
    set_pos(5, 3, 10);
    chk("R2 page", int'(page), 5);
    chk("R2 row", int'(row), 3);
    chk("R2 col", int'(col), 10);
    load(0, 8'hFF);
    chk("R2 page bit7", int'(page), 127);
    load(0, 5);
  endtask

  task automatic t_bad_load();
    load(1, 26);
    chk("R3 row 26 ignored", int'(row), 3);
    load(2, 40);
    chk("R3 col 40 ignored", int'(col), 10);
    load(1, 25);
    chk("R3 row 25 accepted", int'(row), 25);
    load(1, 3);
  endtask

  task automatic t_write();
    lat = 0; nlog = 0;
    do_write(8'hA7);
    chk("R4 nibble count", nlog, 2);
    chk("R4 low addr", int'(log_addr[0]), int'({7'd5, exp_ofs(3, 10), 1'b0}));
    chk("R4 low data", int'(log_dat[0]), 7);
    chk("R4 high addr", int'(log_addr[1]), int'({7'd5, exp_ofs(3, 10), 1'b1}));
    chk("R4 high data", int'(log_dat[1]), 10);
    chk("R5 col advance", int'(col), 11);
    chk("R5 row held", int'(row), 3);
  endtask

  task automatic t_wraps();
    set_pos(5, 3, 39);
    do_write(8'h11);
    chk("R6 col wrap", int'(col), 0);
    chk("R6 row carry", int'(row), 4);
    set_pos(5, 23, 39);
    do_write(8'h22);
    chk("R7 row wrap", int'(row), 0);
    chk("R7 col wrap", int'(col), 0);
    set_pos(5, 24, 39);
    do_write(8'h33);
    chk("R8 row 24 held", int'(row), 24);
    chk("R8 row 24 col", int'(col), 0);
    set_pos(5, 25, 39);
    do_write(8'h44);
    chk("R8 row 25 held", int'(row), 25);
    chk("R8 row 25 col", int'(col), 0);
  endtask

  task automatic t_read();
    logic [7:0] exp;
    lat = 3;
    set_pos(9, 2, 5);
    exp = {nib_model({7'd9, exp_ofs(2, 5), 1'b1}), nib_model({7'd9, exp_ofs(2, 5), 1'b0})};
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
    chk("R9 busy during read", int'(busy), 1);
    chk("R9 col held during read", int'(col), 5);
    wait_idle();
    chk("R9 vld", int'(rdata_vld), 1);
    chk("R9 rdata", int'(rdata), int'(exp));
    chk("R9 col after read", int'(col), 6);
    @(negedge clk);
    chk("R9 vld one cycle", int'(rdata_vld), 0);
  endtask

  task automatic t_busy();
    lat = 4; nlog = 0;
    set_pos(2, 1, 1);
    @(negedge clk);
    wr = 1'b1; wdata = 8'h3C;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    wr = 1'b1; rd = 1'b1; ld_col = 1'b1; ld_row = 1'b1; ld_page = 1'b1; ld_data = 8'd20;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; ld_col = 1'b0; ld_row = 1'b0; ld_page = 1'b0;
    wait_idle();
    repeat (12) @(negedge clk);
    chk("R10 nibbles while busy", nlog, 2);
    chk("R10 col", int'(col), 2);
    chk("R10 row", int'(row), 1);
    chk("R10 page", int'(page), 2);
    chk("R10 data", int'({log_dat[1], log_dat[0]}), 8'h3C);
    lat = 0;
  endtask

  task automatic t_addr();
    lat = 0; nlog = 0;
    set_pos(1, 25, 30);
    do_write(8'h5A);
    chk("R11 modulo offset", int'(log_addr[0]), int'({7'd1, 10'd6, 1'b0}));
    nlog = 0;
    set_pos(127, 0, 0);
    do_write(8'h01);
    chk("R11 page upper bits", int'(log_addr[1]), int'({7'd127, 10'd0, 1'b1}));
    nlog = 0;
    lat = 5;
    set_pos(64, 12, 17);
    do_write(8'hC3);
    chk("R12 addr under latency", int'(log_addr[0]), int'({7'd64, exp_ofs(12, 17), 1'b0}));
    lat = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_bad_load();
    t_write();
    t_wraps();
    t_read();
    t_busy();
    t_addr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule